// File: doc/BRIEF.md
# Nibble Compare and Status Unit

This unit carries out the compare group of a 4-bit microcontroller core. Each cycle it may accept one 10-bit instruction word. If the word is a compare, the unit checks one 4-bit operand against another and writes the outcome into a one-bit status flag. The operands come from the accumulator A, register B, register Y, a 4-bit immediate held in the word, and the nibble read from RAM. There are two compare families. The inequality family reports whether the operands differ. The less-or-equal family reports an unsigned no-borrow result, which is 1 when the first operand is not greater than the second.

Four of the RAM compares also have a direct form that takes two words. The first word is the opcode with bit 8 set. The second word is a 10-bit RAM address. While the unit waits for that address word it raises `dir_phase`. The surrounding core uses that signal to read RAM at the address and return the nibble on `ram_data` in the same cycle. Each instruction ends with a one-cycle `done` pulse, and `cycles` reports how many words the instruction used.

Top module: `nibble_cmp_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, `status`, `done` and `dir_phase` are 0.
- R2: The inequality compares set `status` to 1 when the operands differ and to 0 when they are equal. The encodings are: A vs RAM `0000000100`, B vs RAM `0001000100`, immediate vs RAM `000010iiii`, and Y vs immediate `000111iiii`. The immediate is bits 3..0.
- R3: The less-or-equal compares set `status` to 1 when the first operand is less than or equal to the second as unsigned 4-bit values, and to 0 otherwise. The encodings are: A vs RAM `0000010100`, B vs RAM `0011000100`, immediate vs RAM `000011iiii`, and A vs immediate `101011iiii`.
- R4: The direct forms are the immediate vs RAM and A vs RAM compares of both families with bit 8 of the first word set. The first word of the direct A less-or-equal RAM compare is `0100010100`. For a direct form, `dir_phase` is 1 in the cycle after the first word. The compare uses `ram_data` and the registers from the cycle in which the address word is accepted. The immediate comes from the first word.
- R5: `done` rises for exactly one cycle, in the cycle after the final word of an instruction. In that cycle `cycles` is 1 for a single-word instruction and 2 for a direct form.
- R6: A word that is not a compare leaves `status` unchanged and completes with `done` and `cycles` = 1. This includes B vs RAM or Y vs immediate with bit 8 set.
- R7: No `done` pulse occurs while `dir_phase` is 1 or without an accepted word. `status` changes only in a cycle where `done` is 1.
- R8: The address word of a direct form is never decoded as an opcode, even when it has the bit pattern of a compare.
- R9: While `dir_phase` is 1 and `word_valid` is 0, the unit keeps waiting for the address word. `dir_phase` stays 1 and no `done` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | `word` holds an instruction or address word this cycle |
| word | input | 10 | Instruction word, or direct address word when `dir_phase` is 1 |
| acc_a | input | 4 | Accumulator A |
| reg_b | input | 4 | Register B |
| reg_y | input | 4 | Register Y |
| ram_data | input | 4 | RAM nibble for the compare completing this cycle |
| status | output | 1 | Status flag |
| done | output | 1 | One-cycle pulse marking the end of an instruction |
| cycles | output | 2 | Word and cycle count of the instruction that just completed |
| dir_phase | output | 1 | The unit is waiting for a direct address word |

## Verification
On every cycle the assertions check the framing properties. They confirm that `done` never fires during the address phase or without an accepted word, that `status` moves only together with `done`, that the cycle count matches whether an address phase came before it, and that a stall keeps the address phase open. Only the bench scenarios can show the compare results themselves. These include the equal, differing and boundary operand values of each of the eight compares. They also cover the correct decode of every encoding, the rejection of B and Y compares with bit 8 set, and the rule that an address word shaped like an opcode is still treated as an address.

// File: rtl/nibble_cmp_pkg.sv
package nibble_cmp_pkg;

    localparam int NIB_W  = 4;
    localparam int WORD_W = 10;
    localparam int CYC_W  = 2;
    localparam int DIR_BIT = 8;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_INEM,
        OP_ANEM,
        OP_BNEM,
        OP_YNEI,
        OP_ILEM,
        OP_ALEM,
        OP_BLEM,
        OP_ALEI
    } cmp_op_e;

    typedef struct packed {
        cmp_op_e          op;
        logic             direct;
        logic [NIB_W-1:0] imm;
    } cmp_dec_t;

    typedef struct packed {
        logic              fire;
        cmp_op_e           op;
        logic [NIB_W-1:0]  imm;
        logic [CYC_W-1:0]  cyc;
    } cmp_fire_t;

    localparam logic [WORD_W-1:0] ENC_ANEM = 10'b0000000100;
    localparam logic [WORD_W-1:0] ENC_BNEM = 10'b0001000100;
    localparam logic [WORD_W-1:0] ENC_ALEM = 10'b0000010100;
    localparam logic [WORD_W-1:0] ENC_BLEM = 10'b0011000100;
    localparam logic [5:0] PFX_INEM = 6'b000010;
    localparam logic [5:0] PFX_ILEM = 6'b000011;
    localparam logic [5:0] PFX_YNEI = 6'b000111;
    localparam logic [5:0] PFX_ALEI = 6'b101011;

    function automatic logic direct_capable(cmp_op_e op);
        return (op == OP_INEM) || (op == OP_ANEM) ||
               (op == OP_ILEM) || (op == OP_ALEM);
    endfunction

    function automatic cmp_dec_t decode_word(logic [WORD_W-1:0] w);
        cmp_dec_t d;
        logic [WORD_W-1:0] base;
        base = w;
        base[DIR_BIT] = 1'b0;
        d.imm    = w[NIB_W-1:0];
        d.direct = w[DIR_BIT];
        if (base == ENC_ANEM)      d.op = OP_ANEM;
        else if (base == ENC_BNEM) d.op = OP_BNEM;
        else if (base == ENC_ALEM) d.op = OP_ALEM;
        else if (base == ENC_BLEM) d.op = OP_BLEM;
        else begin
            case (base[WORD_W-1:NIB_W])
                PFX_INEM: d.op = OP_INEM;
                PFX_ILEM: d.op = OP_ILEM;
                PFX_YNEI: d.op = OP_YNEI;
                PFX_ALEI: d.op = OP_ALEI;
                default:  d.op = OP_NONE;
            endcase
        end
        if (d.direct && !direct_capable(d.op)) d.op = OP_NONE;
        if (d.op == OP_NONE) d.direct = 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/nibble_cmp_decoder.sv
module nibble_cmp_decoder
    import nibble_cmp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmp_dec_t          dec
);
    always_comb dec = decode_word(word);
endmodule

// File: rtl/nibble_cmp_sequencer.sv
module nibble_cmp_sequencer
    import nibble_cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      word_valid,
    input  cmp_dec_t  dec,
    output cmp_fire_t fire,
    output logic      dir_phase
);
    logic     phase_q;
    cmp_dec_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            held_q  <= '{op: OP_NONE, direct: 1'b0, imm: '0};
        end else if (word_valid) begin
            if (phase_q) begin
                phase_q <= 1'b0;
            end else if (dec.direct) begin
                phase_q <= 1'b1;
                held_q  <= dec;
            end
        end
    end

    always_comb begin
        fire = '{fire: 1'b0, op: OP_NONE, imm: '0, cyc: '0};
        if (word_valid) begin
            if (phase_q) begin
                fire = '{fire: 1'b1, op: held_q.op, imm: held_q.imm,
                         cyc: CYC_W'(2)};
            end else if (!dec.direct) begin
                fire = '{fire: 1'b1, op: dec.op, imm: dec.imm,
                         cyc: CYC_W'(1)};
            end
        end
    end

    assign dir_phase = phase_q;
endmodule

// File: rtl/nibble_cmp_eval.sv
module nibble_cmp_eval
    import nibble_cmp_pkg::*;
(
    input  cmp_op_e          op,
    input  logic [NIB_W-1:0] imm,
    input  logic [NIB_W-1:0] acc_a,
    input  logic [NIB_W-1:0] reg_b,
    input  logic [NIB_W-1:0] reg_y,
    input  logic [NIB_W-1:0] ram_data,
    output logic             is_cmp,
    output logic             result
);
    always_comb begin
        is_cmp = 1'b1;
        result = 1'b0;
        case (op)
            OP_INEM: result = (imm   != ram_data);
            OP_ANEM: result = (acc_a != ram_data);
            OP_BNEM: result = (reg_b != ram_data);
            OP_YNEI: result = (reg_y != imm);
            OP_ILEM: result = (imm   <= ram_data);
            OP_ALEM: result = (acc_a <= ram_data);
            OP_BLEM: result = (reg_b <= ram_data);
            OP_ALEI: result = (acc_a <= imm);
            default: is_cmp = 1'b0;
        endcase
    end
endmodule

// File: rtl/nibble_cmp_unit.sv
module nibble_cmp_unit
    import nibble_cmp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     word_valid,
    input  logic [WORD_W-1:0]        word,
    input  logic [NIB_W-1:0]         acc_a,
    input  logic [NIB_W-1:0]         reg_b,
    input  logic [NIB_W-1:0]         reg_y,
    input  logic [NIB_W-1:0]         ram_data,
    output logic                     status,
    output logic                     done,
    output logic [CYC_W-1:0]         cycles,
    output logic                     dir_phase
);
    cmp_dec_t  dec;
    cmp_fire_t fire;
    logic      is_cmp;
    logic      result;

    nibble_cmp_decoder u_dec (
        .word (word),
        .dec  (dec)
    );

    nibble_cmp_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .dec        (dec),
        .fire       (fire),
        .dir_phase  (dir_phase)
    );

    nibble_cmp_eval u_eval (
        .op       (fire.op),
        .imm      (fire.imm),
        .acc_a    (acc_a),
        .reg_b    (reg_b),
        .reg_y    (reg_y),
        .ram_data (ram_data),
        .is_cmp   (is_cmp),
        .result   (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
            done   <= 1'b0;
            cycles <= '0;
        end else begin
            done <= fire.fire;
            if (fire.fire) begin
                cycles <= fire.cyc;
                if (is_cmp) status <= result;
            end
        end
    end
endmodule

// File: rtl/nibble_cmp_chk.sv
module nibble_cmp_chk
    import nibble_cmp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             word_valid,
    input logic             status,
    input logic             done,
    input logic [CYC_W-1:0] cycles,
    input logic             dir_phase
);
    p_done_needs_word_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(word_valid));

    p_no_done_in_phase_r7: assert property (@(posedge clk) disable iff (rst)
        dir_phase |-> !done);

    p_status_moves_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(status) |-> done);

    p_cycle_range_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles == CYC_W'(1) || cycles == CYC_W'(2)));

    p_two_after_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (done && cycles == CYC_W'(2)) |-> $past(dir_phase));

    p_one_without_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (done && cycles == CYC_W'(1)) |-> !$past(dir_phase));

    p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (dir_phase && !word_valid) |=> dir_phase);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!status && !done && !dir_phase));
endmodule

bind nibble_cmp_unit nibble_cmp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .status     (status),
    .done       (done),
    .cycles     (cycles),
    .dir_phase  (dir_phase)
);

// File: tb/tb_nibble_cmp_unit.sv
`timescale 1ns/1ps
module tb_nibble_cmp_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       word_valid = 1'b0;
    logic [9:0] word = '0;
    logic [3:0] acc_a = '0, reg_b = '0, reg_y = '0, ram_data = '0;
    logic       status, done, dir_phase;
    logic [1:0] cycles;

    int tests = 0;
    int fails = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    nibble_cmp_unit dut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word(word),
        .acc_a(acc_a), .reg_b(reg_b), .reg_y(reg_y), .ram_data(ram_data),
        .status(status), .done(done), .cycles(cycles), .dir_phase(dir_phase)
    );

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected done", 4'd1, 4'd0);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " status"}, {3'b0, status}, {3'b0, e[2]});
                check({t, " cycles"}, {2'b0, cycles}, {2'b0, e[1:0]});
            end
        end
    end

    task automatic regs(logic [3:0] a, logic [3:0] b, logic [3:0] y, logic [3:0] m);
        acc_a = a; reg_b = b; reg_y = y; ram_data = m;
    endtask

    task automatic one(string tag, logic [9:0] w, logic exp_st);
        @(negedge clk);
        word = w; word_valid = 1'b1;
        exp_q.push_back({exp_st, 2'd1});
        tag_q.push_back(tag);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic two(string tag, logic [9:0] w, logic [9:0] addr,
                       logic [3:0] m, int stall, logic exp_st);
        @(negedge clk);
        word = w; word_valid = 1'b1; ram_data = ~m;
        @(negedge clk);
        word_valid = 1'b0;
        check({tag, " R4 dir_phase"}, {3'b0, dir_phase}, 4'd1);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check({tag, " R9 stall dir_phase"}, {3'b0, dir_phase}, 4'd1);
        end
        word = addr; word_valid = 1'b1; ram_data = m;
        exp_q.push_back({exp_st, 2'd2});
        tag_q.push_back(tag);
        @(negedge clk);
        word_valid = 1'b0;
        check({tag, " R4 phase closed"}, {3'b0, dir_phase}, 4'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status in reset", {3'b0, status}, 4'd0);
        check("R1 done in reset", {3'b0, done}, 4'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 dir_phase after reset", {3'b0, dir_phase}, 4'd0);
        check("R1 status after reset", {3'b0, status}, 4'd0);

        // R2 inequality family
        regs(4'd5, 4'd3, 4'd4, 4'd5); one("R2 ANEM equal", 10'b0000000100, 1'b0);
        regs(4'd5, 4'd3, 4'd4, 4'd6); one("R2 ANEM differ", 10'b0000000100, 1'b1);
        regs(4'd0, 4'd3, 4'd4, 4'd3); one("R2 BNEM equal", 10'b0001000100, 1'b0);
        regs(4'd0, 4'd9, 4'd4, 4'd3); one("R2 BNEM differ", 10'b0001000100, 1'b1);
        regs(4'd0, 4'd0, 4'd4, 4'd7); one("R2 INEM equal", 10'b0000100111, 1'b0);
        regs(4'd0, 4'd0, 4'd4, 4'd2); one("R2 INEM differ", 10'b0000100111, 1'b1);
        regs(4'd0, 4'd0, 4'd4, 4'd0); one("R2 YNEI equal", 10'b0001110100, 1'b0);
        regs(4'd0, 4'd0, 4'd4, 4'd0); one("R2 YNEI differ", 10'b0001110101, 1'b1);

        // R3 less-or-equal family
        regs(4'd3, 4'd0, 4'd0, 4'd3); one("R3 ALEM equal", 10'b0000010100, 1'b1);
        regs(4'd4, 4'd0, 4'd0, 4'd3); one("R3 ALEM greater", 10'b0000010100, 1'b0);
        regs(4'd0, 4'd0, 4'd0, 4'd15); one("R3 ALEM extremes", 10'b0000010100, 1'b1);
        regs(4'd0, 4'd15, 4'd0, 4'd14); one("R3 BLEM greater", 10'b0011000100, 1'b0);
        regs(4'd0, 4'd15, 4'd0, 4'd15); one("R3 BLEM equal top", 10'b0011000100, 1'b1);
        regs(4'd0, 4'd0, 4'd0, 4'd1); one("R3 ILEM greater", 10'b0000110010, 1'b0);
        regs(4'd0, 4'd0, 4'd0, 4'd2); one("R3 ILEM less", 10'b0000110001, 1'b1);
        regs(4'd9, 4'd0, 4'd0, 4'd0); one("R3 ALEI greater", 10'b1010111000, 1'b0);
        regs(4'd8, 4'd0, 4'd0, 4'd0); one("R3 ALEI less", 10'b1010111001, 1'b1);

        // R6 non-compare words keep status (currently 1)
        regs(4'd0, 4'd0, 4'd0, 4'd0); one("R6 other word keeps 1", 10'b1111111111, 1'b1);
        regs(4'd0, 4'd3, 4'd0, 4'd3); one("R6 BNEM with bit8 rejected", 10'b0101000100, 1'b1);
        regs(4'd0, 4'd0, 4'd4, 4'd0); one("R6 YNEI with bit8 rejected", 10'b0101110100, 1'b1);
        regs(4'd5, 4'd0, 4'd0, 4'd5); one("R2 ANEM clear", 10'b0000000100, 1'b0);
        regs(4'd0, 4'd0, 4'd0, 4'd9); one("R6 zero word keeps 0", 10'b0000000000, 1'b0);

        // R4/R8 direct forms; address word shaped like ANEM
        regs(4'd5, 4'd0, 4'd0, 4'd0);
        two("R4 R8 ANEMD equal", 10'b0100000100, 10'b0000000100, 4'd5, 0, 1'b0);
        regs(4'd2, 4'd0, 4'd0, 4'd0);
        two("R4 R9 ALEMD stalled", 10'b0100010100, 10'b1111000001, 4'd7, 3, 1'b1);
        regs(4'd0, 4'd0, 4'd0, 4'd0);
        two("R4 INEMD equal", 10'b0100100110, 10'b0000100110, 4'd6, 1, 1'b0);
        two("R4 ILEMD equal", 10'b0100110011, 10'b1010110000, 4'd3, 0, 1'b1);
        regs(4'd9, 4'd0, 4'd0, 4'd0);
        two("R4 ALEMD greater", 10'b0100010100, 10'b0000010100, 4'd8, 0, 1'b0);

        // R5 single word after direct is 1 cycle again
        regs(4'd1, 4'd0, 4'd0, 4'd2); one("R5 single after direct", 10'b0000000100, 1'b1);

        repeat (4) @(negedge clk);
        check("R5 all done pulses seen", 4'(exp_q.size()), 4'd0);
        check("R7 no stray done", {3'b0, done}, 4'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule